// File: doc/BRIEF.md
# Threshold-Triggered Sample Frame Capture

This block sits on one channel of a multi-channel digitiser. It watches a continuous stream of signed ADC samples and cuts fixed-length frames of 32 samples out of it whenever the signal rises above a programmable threshold. Each frame also carries some history from before the trigger, up to 10 samples, so the leading edge of the pulse is kept. If the pulse is still above the threshold on the last sample of a frame, a further frame of the next 32 samples follows at once and is flagged as a continuation.

A capture can also be started from outside the channel. In neighbour mode the crossing outputs of the two adjacent channels start captures here. In global mode a chip-wide trigger line does so. Completed samples go into a frame FIFO and leave on a valid/ready stream. Each beat carries start and end markers and a header: the channel number, the index of the frame's first sample, the number of history samples and the continuation flag. When the FIFO cannot take a whole frame, that frame is discarded in full and counted.

Top module: `trig_frame_capture`

## Requirements
- R1: `cross_out` is high in a cycle exactly when `smp_valid` is high and `smp_data` is strictly greater than `thr`, both taken as signed 16-bit values. A sample equal to `thr` does not count.
- R2: Every frame is exactly 32 beats long. `m_sof` is high on its first beat only and `m_eof` on its last beat only.
- R3: A capture started by the sample of index i begins at sample i-p and carries consecutive samples. Here p = min(10, number of valid samples received since reset). The value of p is 10 whenever an earlier capture has completed. `m_pre` reports p on every beat of that frame.
- R4: Triggers are ignored from the triggering sample until the valid sample of index L+10, where L is the index of the last sample of the capture. The first sample that can start a new capture is L+11, so no sample is ever sent twice.
- R5: If the last sample of a frame is greater than `thr`, the next frame starts with the very next sample, with `m_cont`=1 and `m_pre`=0. This repeats for as long as frames keep ending above the threshold.
- R6: `mode` encoding: 0 = own crossing only; 1 = own crossing or `nbr_lo_trig` or `nbr_hi_trig`; 2 = own crossing or `glob_trig`; 3 behaves as 0. External trigger inputs count only in cycles where `smp_valid` is high.
- R7: `m_ts` is the index of the frame's first sample, counting valid samples from 0 after reset. `m_chan` equals the parameter `CHAN_ID`. Both are constant across the beats of a frame.
- R8: At the start of each frame, the frame is kept only if the FIFO (depth 64 samples) has at least 32 free entries. Otherwise none of its beats is output and `ovf_count` increases by one.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid` and all beat fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A new sample is present |
| smp_data | input | 16 | Signed sample |
| thr | input | 16 | Signed trigger threshold |
| mode | input | 2 | Trigger source selection |
| nbr_lo_trig | input | 1 | Crossing of the lower neighbour channel |
| nbr_hi_trig | input | 1 | Crossing of the upper neighbour channel |
| glob_trig | input | 1 | Chip-wide trigger |
| cross_out | output | 1 | This channel's own crossing, for the neighbours |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts the beat |
| m_data | output | 16 | Sample of the beat |
| m_sof | output | 1 | First beat of a frame |
| m_eof | output | 1 | Last beat of a frame |
| m_cont | output | 1 | Frame continues the previous one |
| m_pre | output | 4 | Number of history samples in the frame |
| m_ts | output | 32 | Index of the frame's first sample |
| m_chan | output | 8 | Channel number |
| ovf_count | output | 16 | Frames dropped for lack of FIFO room |

## Verification
The bench places pulses on the second sample after reset, so fewer than 10 history samples exist. A design that padded the history with stale delay-line contents would show wrong leading samples or a wrong `m_pre`. It drives long pulses that span several frames: a design that missed chaining would leave a gap, and one that re-armed early would repeat samples or start a spurious frame. Sample values sit exactly at the threshold and thresholds are negative, which catches an unsigned or a greater-or-equal compare. Neighbour and global trigger pulses are driven in every mode, including cycles without a valid sample, so a wrong mode decode produces extra or missing frames. A phase with the output stalled fills the FIFO: a design that kept a partial frame, or failed to count the dropped ones, emits a truncated frame or reports the wrong count.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CAPT = 2'd2
    } cap_state_e;

    localparam logic [1:0] TM_LOCAL     = 2'd0;
    localparam logic [1:0] TM_NEIGHBOUR = 2'd1;
    localparam logic [1:0] TM_GLOBAL    = 2'd2;

endpackage

// File: rtl/cap_trig_sel.sv
module cap_trig_sel
    import cap_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       own,
    input  logic       lo,
    input  logic       hi,
    input  logic       glob,
    output logic       trig
);
    always_comb begin
        case (mode)
            TM_NEIGHBOUR: trig = own | lo | hi;
            TM_GLOBAL:    trig = own | glob;
            default:      trig = own;
        endcase
    end
endmodule

// File: rtl/cap_delay_line.sv
module cap_delay_line #(
    parameter int DW    = 16,
    parameter int DEPTH = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] tap
);
    logic [DW-1:0] sr_d [DEPTH];
    logic [DW-1:0] sr_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) sr_d[i] = sr_q[i];
        if (en) begin
            sr_d[0] = din;
            for (int i = 1; i < DEPTH; i++) sr_d[i] = sr_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) sr_q[i] <= sr_d[i];
        end
    end

    // sample received DEPTH valid cycles before the current input
    assign tap = sr_q[DEPTH-1];
endmodule

// File: rtl/cap_sync_fifo.sv
module cap_sync_fifo #(
    parameter int W     = 55,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         rd_valid,
    output logic [AW:0]  count
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } ptr_t;

    ptr_t        p_d, p_q;
    logic [W-1:0] mem [DEPTH];
    logic         do_rd;
    logic         full;

    assign full     = (p_q.cnt == (AW+1)'(DEPTH));
    assign rd_valid = (p_q.cnt != '0);
    assign do_rd    = rd_en && rd_valid;

    always_comb begin
        p_d = p_q;
        if (wr_en)  p_d.wp = p_q.wp + 1'b1;
        if (do_rd)  p_d.rp = p_q.rp + 1'b1;
        case ({wr_en, do_rd})
            2'b10:   p_d.cnt = p_q.cnt + 1'b1;
            2'b01:   p_d.cnt = p_q.cnt - 1'b1;
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[p_q.wp] <= wr_data;
    end

    assign rd_data = mem[p_q.rp];
    assign count   = p_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full); // R8
endmodule

// File: rtl/trig_frame_capture.sv
module trig_frame_capture
    import cap_pkg::*;
#(
    parameter int DW         = 16,
    parameter int TSW        = 32,
    parameter int FRAME_LEN  = 32,
    parameter int PRE_MAX    = 10,
    parameter int PRE_W      = 4,
    parameter int FIFO_DEPTH = 64,
    parameter int CHAN_W     = 8,
    parameter int CHAN_ID    = 0,
    parameter int OVF_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DW-1:0]     smp_data,
    input  logic [DW-1:0]     thr,
    input  logic [1:0]        mode,
    input  logic              nbr_lo_trig,
    input  logic              nbr_hi_trig,
    input  logic              glob_trig,
    output logic              cross_out,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DW-1:0]     m_data,
    output logic              m_sof,
    output logic              m_eof,
    output logic              m_cont,
    output logic [PRE_W-1:0]  m_pre,
    output logic [TSW-1:0]    m_ts,
    output logic [CHAN_W-1:0] m_chan,
    output logic [OVF_W-1:0]  ovf_count
);
    localparam int AW = $clog2(FIFO_DEPTH);
    localparam int CW = $clog2(FRAME_LEN + 1);
    localparam int EW = 1 + PRE_W + TSW + 2 + DW;
    localparam logic [PRE_W-1:0] PRE_C   = PRE_W'(PRE_MAX);
    localparam logic [CW-1:0]    FRAME_C = CW'(FRAME_LEN);
    localparam logic [AW:0]      ROOM_C  = (AW+1)'(FIFO_DEPTH - FRAME_LEN);

    typedef struct packed {
        cap_state_e       st;
        logic [CW-1:0]    cnt;
        logic             keep;
        logic             cont;
        logic [PRE_W-1:0] pre;
        logic [PRE_W-1:0] avail;
        logic [TSW-1:0]   fts;
        logic [TSW-1:0]   ts;
        logic [OVF_W-1:0] ovf;
    } ctl_t;

    ctl_t          d, q;
    logic          own_cross, trig, start, emit, room;
    logic [CW-1:0] cur_cnt;
    logic [DW-1:0] tap;
    logic          wr_en;
    logic [EW-1:0] wr_entry, rd_entry;
    logic [AW:0]   fifo_cnt;

    assign own_cross = smp_valid && ($signed(smp_data) > $signed(thr));
    assign cross_out = own_cross;

    cap_trig_sel u_sel (
        .mode (mode),
        .own  (own_cross),
        .lo   (nbr_lo_trig & smp_valid),
        .hi   (nbr_hi_trig & smp_valid),
        .glob (glob_trig & smp_valid),
        .trig (trig)
    );

    cap_delay_line #(.DW(DW), .DEPTH(PRE_MAX)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (smp_valid),
        .din   (smp_data),
        .tap   (tap)
    );

    always_comb begin
        d        = q;
        start    = 1'b0;
        emit     = 1'b0;
        cur_cnt  = '0;
        wr_en    = 1'b0;
        wr_entry = '0;
        room     = (fifo_cnt <= ROOM_C);
        if (smp_valid) begin
            d.ts = q.ts + 1'b1;
            case (q.st)
                ST_IDLE: begin
                    if (trig) begin
                        d.pre  = q.avail;
                        d.cont = 1'b0;
                        if (q.avail == PRE_C) begin
                            start = 1'b1;
                        end else begin
                            d.st  = ST_WAIT;
                            d.cnt = CW'(PRE_C - q.avail);
                        end
                    end else if (q.avail != PRE_C) begin
                        d.avail = q.avail + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (q.cnt == CW'(1)) start = 1'b1;
                    else                 d.cnt = q.cnt - 1'b1;
                end
                default: emit = 1'b1;
            endcase
            if (start) begin
                emit   = 1'b1;
                d.keep = room;
                d.fts  = q.ts - TSW'(PRE_MAX);
                if (!room) d.ovf = q.ovf + 1'b1;
            end
            if (emit) begin
                cur_cnt  = start ? FRAME_C : q.cnt;
                wr_en    = d.keep;
                wr_entry = {d.cont, d.pre, d.fts,
                            cur_cnt == FRAME_C, cur_cnt == CW'(1), tap};
                if (cur_cnt == CW'(1)) begin
                    if ($signed(tap) > $signed(thr)) begin
                        d.st   = ST_WAIT;
                        d.cnt  = CW'(1);
                        d.cont = 1'b1;
                        d.pre  = '0;
                    end else begin
                        d.st    = ST_IDLE;
                        d.avail = PRE_C;
                        d.cont  = 1'b0;
                    end
                end else begin
                    d.st  = ST_CAPT;
                    d.cnt = cur_cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    cap_sync_fifo #(.W(EW), .DEPTH(FIFO_DEPTH), .AW(AW)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_entry),
        .rd_en    (m_ready),
        .rd_data  (rd_entry),
        .rd_valid (m_valid),
        .count    (fifo_cnt)
    );

    assign {m_cont, m_pre, m_ts, m_sof, m_eof, m_data} = rd_entry;
    assign m_chan    = CHAN_W'(CHAN_ID);
    assign ovf_count = q.ovf;

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_pre <= PRE_C)); // R3
    AST_CONT_NO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_cont) |-> (m_pre == '0)); // R5
    AST_SOF_EOF_APART: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> !(m_sof && m_eof)); // R2
    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable({m_data, m_sof, m_eof, m_ts}))); // R9
    AST_DROP_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !room) |=> (ovf_count == OVF_W'($past(ovf_count) + 1'b1))); // R8
endmodule

// File: tb/sim_trig_frame_capture.sv
`timescale 1ns/1ps
module sim_trig_frame_capture;
    localparam int MAXN  = 700;
    localparam int BEATS = 1500;
    localparam int FL    = 32;
    localparam int PREM  = 10;

    logic clk = 0;
    logic rst_n = 0;
    logic smp_valid = 0;
    logic [15:0] smp_data = '0;
    logic [15:0] thr = '0;
    logic [1:0] mode = '0;
    logic nbr_lo_trig = 0, nbr_hi_trig = 0, glob_trig = 0;
    logic cross_out, m_valid, m_sof, m_eof, m_cont;
    logic m_ready = 0;
    logic [15:0] m_data;
    logic [3:0] m_pre;
    logic [31:0] m_ts;
    logic [7:0] m_chan;
    logic [15:0] ovf_count;

    always #5 clk = ~clk;

    trig_frame_capture #(.CHAN_ID(5)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .thr(thr), .mode(mode), .nbr_lo_trig(nbr_lo_trig), .nbr_hi_trig(nbr_hi_trig),
        .glob_trig(glob_trig), .cross_out(cross_out), .m_valid(m_valid),
        .m_ready(m_ready), .m_data(m_data), .m_sof(m_sof), .m_eof(m_eof),
        .m_cont(m_cont), .m_pre(m_pre), .m_ts(m_ts), .m_chan(m_chan),
        .ovf_count(ovf_count)
    );

    int total = 0;
    int bad = 0;

    logic signed [15:0] smp [MAXN];
    bit lo_b [MAXN];
    bit hi_b [MAXN];
    bit gl_b [MAXN];
    int ef_start [64];
    int ef_pre [64];
    bit ef_cont [64];
    int nf;

    logic [15:0] g_data [BEATS];
    bit g_sof [BEATS];
    bit g_eof [BEATS];
    bit g_cont [BEATS];
    int g_pre [BEATS];
    logic [31:0] g_ts [BEATS];
    logic [7:0] g_chan [BEATS];
    int ng;

    bit rdy_rand, rdy_zero;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit trig_at(input int i, input int md, input int th);
        bit t;
        t = (int'(smp[i]) > th);
        if (md == 1) t = t | lo_b[i] | hi_b[i];
        if (md == 2) t = t | gl_b[i];
        return t;
    endfunction

    task automatic gen(input int th, input int n, input bit early);
        int pl = 0;
        for (int i = 0; i < n; i++) begin
            bit tail = (i >= n - 100);
            if (!tail && early && i == 2) pl = 4;
            if (!tail && pl == 0 && i > 2 && ($urandom % 40) == 0) pl = 1 + ($urandom % 45);
            if (!tail && pl > 0) begin
                smp[i] = 16'(th + 1 + ($urandom % 800));
                pl--;
            end else begin
                smp[i] = 16'(th - int'($urandom % 600));
            end
            lo_b[i] = !tail && (i > 2) && (($urandom % 70) == 0);
            hi_b[i] = !tail && (i > 2) && (($urandom % 70) == 0);
            gl_b[i] = !tail && (i > 2) && (($urandom % 70) == 0);
        end
    endtask

    // Expected frames built from R3, R4, R5, R6 in the sample-index domain
    task automatic model(input int md, input int th, input int n);
        int last_end = -1;
        int busy = -1;
        nf = 0;
        for (int i = 0; i < n; i++) begin
            if (i > busy && trig_at(i, md, th)) begin
                int p = i - (last_end + 1);
                int f, L;
                bit c = 0;
                if (p > PREM) p = PREM;
                f = i - p;
                forever begin
                    ef_start[nf] = f; ef_pre[nf] = p; ef_cont[nf] = c; nf++;
                    L = f + FL - 1;
                    if (L < n && int'(smp[L]) > th && nf < 64) begin
                        f = L + 1; p = 0; c = 1;
                    end else break;
                end
                last_end = L;
                busy = L + PREM;
            end
        end
    endtask

    task automatic step(input bit give, input int idx, input int th);
        bit r;
        @(negedge clk);
        r = rdy_zero ? 1'b0 : (rdy_rand ? (($urandom % 4) != 0) : 1'b1);
        if (m_valid && r && ng < BEATS) begin
            g_data[ng] = m_data; g_sof[ng] = m_sof; g_eof[ng] = m_eof;
            g_cont[ng] = m_cont; g_pre[ng] = int'(m_pre); g_ts[ng] = m_ts;
            g_chan[ng] = m_chan;
            ng++;
        end
        m_ready = r;
        smp_valid = give;
        if (give) begin
            smp_data = smp[idx];
            nbr_lo_trig = lo_b[idx]; nbr_hi_trig = hi_b[idx]; glob_trig = gl_b[idx];
        end else begin
            smp_data = 16'($urandom);
            nbr_lo_trig = $urandom % 2; nbr_hi_trig = $urandom % 2; glob_trig = $urandom % 2;
        end
        #1;
        if (give) chk(cross_out == (int'(smp[idx]) > th), "R1 cross_out", cross_out, int'(smp[idx]) > th);
        else      chk(cross_out == 1'b0, "R1 cross_out idle", cross_out, 0);
    endtask

    task automatic run_phase(input int md, input int th, input bit ovf_ph, input int n, input bit early);
        int keepf, idle;
        gen(th, n, early);
        model(md, th, n);
        ng = 0;
        rdy_zero = ovf_ph;
        rdy_rand = !ovf_ph;
        @(negedge clk);
        rst_n = 0; smp_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        thr = 16'(th); mode = 2'(md);
        #1;
        chk(m_valid == 1'b0, "reset m_valid", m_valid, 0);
        chk(ovf_count == 16'd0, "reset ovf_count", ovf_count, 0);
        for (int i = 0; i < n; i++) begin
            while (($urandom % 10) >= 6) step(0, 0, th);
            step(1, i, th);
        end
        step(0, 0, th);
        keepf = ovf_ph ? ((nf < 2) ? nf : 2) : nf;
        // R8: dropped frames are counted, none in free-running phases
        chk(int'(ovf_count) == nf - keepf, "R8 ovf_count", ovf_count, nf - keepf);
        rdy_zero = 0;
        idle = 0;
        for (int k = 0; k < 4000 && idle < 40; k++) begin
            step(0, 0, th);
            idle = m_valid ? 0 : idle + 1;
        end
        // R2 R4 R6: number of beats matches the frames expected for this mode
        chk(ng == keepf * FL, "R2 R4 R6 beat count", ng, keepf * FL);
        for (int k = 0; k < keepf && (k + 1) * FL <= ng; k++) begin
            bit d_ok = 1, m_ok = 1, t_ok = 1, p_ok = 1, c_ok = 1, h_ok = 1;
            for (int b = 0; b < FL; b++) begin
                int g = k * FL + b;
                if (g_data[g] != smp[ef_start[k] + b]) d_ok = 0;
                if (g_sof[g] != (b == 0) || g_eof[g] != (b == FL - 1)) m_ok = 0;
                if (g_ts[g] != 32'(ef_start[k])) t_ok = 0;
                if (g_pre[g] != ef_pre[k]) p_ok = 0;
                if (g_cont[g] != ef_cont[k]) c_ok = 0;
                if (g_chan[g] != 8'd5) h_ok = 0;
            end
            chk(d_ok, ef_cont[k] ? "R5 chained data" : "R3 frame data", g_data[k*FL], smp[ef_start[k]]);
            chk(m_ok, "R2 sof/eof markers", g_sof[k*FL], 1);
            chk(t_ok, "R7 timestamp", g_ts[k*FL], ef_start[k]);
            chk(p_ok, "R3 pre count", g_pre[k*FL], ef_pre[k]);
            chk(c_ok, "R5 continuation flag", g_cont[k*FL], ef_cont[k]);
            chk(h_ok, "R7 channel id", g_chan[k*FL], 5);
        end
    endtask

    bit finished = 0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        run_phase(0, 500, 0, 600, 1);   // R1 R3 R5: local, early pulse, random backpressure R9
        run_phase(1, 500, 0, 600, 0);   // R6 neighbour mode
        run_phase(2, -300, 0, 600, 0);  // R6 global mode, negative threshold R1
        run_phase(3, -300, 0, 600, 1);  // R6 mode 3 ignores external triggers
        run_phase(0, 500, 1, 600, 0);   // R8 output stalled, FIFO fills
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule